// File: doc/BRIEF.md
# PWM Contrast and Backlight Generator

This block drives one pulse-width-modulated pin for a display contrast input or a backlight supply. The system clock is first divided by a selectable power-of-two prescaler. Each prescaled tick advances an 8-bit period counter, so one period is 256 ticks long. The pin is active while that counter is below an applied duty value.

Two registers set the block up. The control register holds an enable bit, a polarity bit and the prescaler select. The duty register is 8 bits wide, can be read back, and comes out of reset at 0xC8. A duty written while the generator runs is taken up at the next period boundary, so no period is ever cut short or stretched. A write to the control register restarts the period from count zero.

Top module: `pwm_dimmer`

## Requirements
- R1: After reset the duty readback is 0xC8, the control register is zero and `pwm_o` is 0.
- R2: A write on `duty_we_i` stores `duty_wdata_i`, and `duty_o` shows it from the clock after the write edge.
- R3: The control register uses bits [3:2] as the prescaler select: values 0, 1, 2 and 3 give one tick every 1, 2, 4 and 8 clocks. A period is 256 ticks.
- R4: With bit 1 of the control register at 0 (positive polarity), the output is high while the tick count is below the applied duty. Any 256×D consecutive cycles in steady state therefore hold duty×D high cycles, where D is the divisor.
- R5: With bit 1 at 1 (inverted polarity), the output is the complement of the positive-polarity waveform.
- R6: Bit 0 of the control register enables the generator. While it is 0, the output sits at the inactive level: 0 for positive polarity and 1 for inverted. Writing the control register to zero stops the output. Any control write clears the prescaler and the tick count, and loads the applied duty from the duty register.
- R7: A duty written while the generator is enabled becomes the applied duty only at the tick that wraps the count from 255 to 0, or at the next control write.
- R8: An applied duty of 0 keeps the output at its inactive level for the whole period. A duty of 0 together with a control value of 0 holds the pin low.
- R9: An applied duty of 255 gives an active output on every tick except count 255.
- R10: `pwm_o` is registered. In clock n+1 it reflects the enable, the polarity, the tick count and the applied duty as they were held in clock n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control write data: [0] enable, [1] invert, [3:2] prescaler select |
| duty_we_i | input | 1 | Duty register write strobe |
| duty_wdata_i | input | 8 | Duty write data |
| duty_o | output | 8 | Duty register readback |
| pwm_o | output | 1 | PWM output pin |

## Verification
The duty readback changes on the write edge itself. The pin reacts one register stage after the tick count that produces it, and a new duty reaches the pin only after the wrap tick or a control write, plus that same register stage. The bench drives inputs on falling edges. It runs a model that updates its state on each rising edge from the same pre-edge inputs, and it compares at the next falling edge, so every expected value already includes the output register. The directed window checks wait three cycles after the restarting control write and then count the high cycles over exactly one full period of clocks.

// File: rtl/pwm_dimmer_pkg.sv
package pwm_dimmer_pkg;
  localparam int unsigned PSC_SEL_W = 2;
  localparam int unsigned CTRL_W    = PSC_SEL_W + 2;

  typedef struct packed {
    logic [PSC_SEL_W-1:0] psel;
    logic                 inv;
    logic                 en;
  } ctrl_t;
endpackage

// File: rtl/pwm_dimmer_regs.sv
module pwm_dimmer_regs
  import pwm_dimmer_pkg::*;
#(
  parameter int unsigned DUTY_W = 8,
  parameter logic [DUTY_W-1:0] DUTY_RST = 8'hC8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              duty_we_i,
  input  logic [DUTY_W-1:0] duty_wdata_i,
  output ctrl_t             ctrl_o,
  output logic [DUTY_W-1:0] duty_o
);
  ctrl_t             ctrl_q;
  logic [DUTY_W-1:0] duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      duty_q <= DUTY_RST;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
      if (duty_we_i) duty_q <= duty_wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign duty_o = duty_q;
endmodule

// File: rtl/pwm_dimmer_prescaler.sv
module pwm_dimmer_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] psel_i,
  output logic             tick_o
);
  localparam int unsigned NSEL  = 1 << SEL_W;
  localparam int unsigned CNT_W = (NSEL > 2) ? NSEL - 1 : 1;

  logic [CNT_W-1:0] pcnt_q;
  logic [NSEL-1:0]  term;

  // one terminal compare per divisor setting, divisor = 2**s
  for (genvar s = 0; s < NSEL; s++) begin : g_term
    assign term[s] = (pcnt_q >= CNT_W'((1 << s) - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (!en_i || restart_i) pcnt_q <= '0;
    else if (term[psel_i])      pcnt_q <= '0;
    else                        pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick_o = en_i & term[psel_i];
endmodule

// File: rtl/pwm_dimmer_core.sv
module pwm_dimmer_core #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              inv_i,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] cnt_o,
  output logic [DUTY_W-1:0] duty_act_o,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] duty_act_q;
  logic              pwm_q;
  logic              wrap;
  logic              active;

  assign wrap   = tick_i & (&cnt_q);
  assign active = en_i & (cnt_q < duty_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      duty_act_q <= '0;
    end else if (!en_i || restart_i) begin
      cnt_q      <= '0;
      duty_act_q <= duty_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) duty_act_q <= duty_i; // take new duty only on period boundary
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= active ^ inv_i;
  end

  assign cnt_o      = cnt_q;
  assign duty_act_o = duty_act_q;
  assign pwm_o      = pwm_q;
endmodule

// File: rtl/pwm_dimmer.sv
module pwm_dimmer
  import pwm_dimmer_pkg::*;
#(
  parameter int unsigned DUTY_W = 8,
  parameter logic [DUTY_W-1:0] DUTY_RST = 8'hC8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              duty_we_i,
  input  logic [DUTY_W-1:0] duty_wdata_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              pwm_o
);
  ctrl_t                ctrl;
  logic                 en_w;
  logic                 inv_w;
  logic [PSC_SEL_W-1:0] psel_w;
  logic                 tick_w;
  logic [DUTY_W-1:0]    cnt_w;
  logic [DUTY_W-1:0]    duty_act_w;

  pwm_dimmer_regs #(.DUTY_W(DUTY_W), .DUTY_RST(DUTY_RST)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .duty_we_i    (duty_we_i),
    .duty_wdata_i (duty_wdata_i),
    .ctrl_o       (ctrl),
    .duty_o       (duty_o)
  );

  assign en_w   = ctrl.en;
  assign inv_w  = ctrl.inv;
  assign psel_w = ctrl.psel;

  pwm_dimmer_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_w),
    .restart_i (ctrl_we_i),
    .psel_i    (psel_w),
    .tick_o    (tick_w)
  );

  pwm_dimmer_core #(.DUTY_W(DUTY_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_w),
    .inv_i      (inv_w),
    .restart_i  (ctrl_we_i),
    .tick_i     (tick_w),
    .duty_i     (duty_o),
    .cnt_o      (cnt_w),
    .duty_act_o (duty_act_w),
    .pwm_o      (pwm_o)
  );
endmodule

// File: rtl/pwm_dimmer_chk.sv
module pwm_dimmer_chk #(
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned SEL_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic              duty_we_i,
  input logic [DUTY_W-1:0] duty_wdata_i,
  input logic [DUTY_W-1:0] duty_o,
  input logic              pwm_o,
  input logic              en_w,
  input logic              inv_w,
  input logic [SEL_W-1:0]  psel_w,
  input logic              tick_w,
  input logic [DUTY_W-1:0] cnt_w,
  input logic [DUTY_W-1:0] duty_act_w
);
  localparam int unsigned GAP_W = (1 << SEL_W) + 1;

  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gap_q <= '0;
    else if (!en_w || ctrl_we_i || tick_w) gap_q <= '0;
    else                                  gap_q <= gap_q + 1'b1;
  end

  p_duty_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_we_i |=> duty_o == $past(duty_wdata_i));

  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_w |-> (en_w && gap_q == GAP_W'((1 << psel_w) - 1)));

  p_active_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && !inv_w && cnt_w < duty_act_w) |=> pwm_o);

  p_inverted_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && inv_w && cnt_w < duty_act_w) |=> !pwm_o);

  p_idle_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |=> pwm_o == $past(inv_w));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_w || ctrl_we_i) |=> cnt_w == '0);

  p_duty_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && !ctrl_we_i && !(tick_w && (&cnt_w))) |=> $stable(duty_act_w));

  p_zero_duty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && duty_act_w == '0) |=> pwm_o == $past(inv_w));
endmodule

bind pwm_dimmer pwm_dimmer_chk #(.DUTY_W(DUTY_W), .SEL_W(pwm_dimmer_pkg::PSC_SEL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .duty_we_i    (duty_we_i),
  .duty_wdata_i (duty_wdata_i),
  .duty_o       (duty_o),
  .pwm_o        (pwm_o),
  .en_w         (en_w),
  .inv_w        (inv_w),
  .psel_w       (psel_w),
  .tick_w       (tick_w),
  .cnt_w        (cnt_w),
  .duty_act_w   (duty_act_w)
);

// File: tb/tb_pwm_dimmer.sv
`timescale 1ns/1ps
module tb_pwm_dimmer;
  localparam int HALF = 4; // 125 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [3:0] ctrl_wdata = '0;
  logic       duty_we = 1'b0;
  logic [7:0] duty_wdata = '0;
  logic [7:0] duty_o;
  logic       pwm_o;

  int checks = 0;
  int errors = 0;
  bit model_cmp = 1'b0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  pwm_dimmer dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (ctrl_wdata),
    .duty_we_i    (duty_we),
    .duty_wdata_i (duty_wdata),
    .duty_o       (duty_o),
    .pwm_o        (pwm_o)
  );

  // reference state, stepped from the requirement text
  logic [3:0] m_ctrl;
  logic [7:0] m_duty, m_cnt, m_act;
  int         m_pcnt;
  logic       m_pwm;

  function automatic int divisor(input logic [3:0] c);
    return 1 << c[3:2]; // R3
  endfunction

  function automatic logic level(input logic [3:0] c, input logic [7:0] cnt, input logic [7:0] act);
    logic a;
    a = c[0] && (cnt < act);       // R4, R6
    return a ^ c[1];               // R5
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_duty <= 8'hC8; m_cnt <= '0; m_act <= '0; m_pcnt <= 0; m_pwm <= 1'b0;
    end else begin
      m_pwm <= level(m_ctrl, m_cnt, m_act); // R10
      if (!m_ctrl[0] || ctrl_we) begin
        m_pcnt <= 0; m_cnt <= '0; m_act <= m_duty;
      end else if (m_pcnt == divisor(m_ctrl) - 1) begin
        m_pcnt <= 0;
        m_cnt  <= m_cnt + 8'd1;
        if (m_cnt == 8'hFF) m_act <= m_duty; // R7
      end else begin
        m_pcnt <= m_pcnt + 1;
      end
      if (ctrl_we) m_ctrl <= ctrl_wdata;
      if (duty_we) m_duty <= duty_wdata;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_cmp && rst_n && !done) begin
      check("R10 pwm_o vs model", int'(pwm_o), int'(m_pwm));
      check("R2 duty_o vs model", int'(duty_o), int'(m_duty));
    end
  end

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_duty(input logic [7:0] v);
    @(negedge clk); duty_we = 1'b1; duty_wdata = v;
    @(negedge clk); duty_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // high cycles over one full period after a restarting control write
  task automatic window(input string req, input logic [3:0] c, input logic [7:0] d);
    int high;
    int per;
    int exp;
    wr_duty(d);
    wr_ctrl(c);
    idle(3);
    per = 256 * divisor(c);
    high = 0;
    for (int i = 0; i < per; i++) begin
      if (pwm_o) high++;
      @(negedge clk);
    end
    exp = int'(d) * divisor(c);
    if (c[1]) exp = per - exp;
    check(req, high, exp);
  endtask

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_0C8;
    void'($urandom(seed));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 duty reset", int'(duty_o), 8'hC8);
    check("R1 pwm reset", int'(pwm_o), 0);
    idle(20);
    check("R6 disabled stays low", int'(pwm_o), 0);
    model_cmp = 1'b1;

    wr_duty(8'h3A);
    check("R2 duty readback", int'(duty_o), 8'h3A);

    window("R4 div1 duty 0x40", 4'b00_0_1, 8'h40);
    window("R3 div8 duty 0xC8", 4'b11_0_1, 8'hC8);
    window("R3 div2 duty 0x11", 4'b01_0_1, 8'h11);
    window("R9 duty 0xFF div4", 4'b10_0_1, 8'hFF);
    window("R5 inverted div2 0xFF", 4'b01_1_1, 8'hFF);
    window("R5 inverted div1 0x20", 4'b00_1_1, 8'h20);
    window("R8 duty zero enabled", 4'b00_0_1, 8'h00);

    wr_ctrl(4'b0010);
    idle(2);
    check("R6 inverted idle level", int'(pwm_o), 1);
    wr_duty(8'h00);
    wr_ctrl(4'b0000);
    idle(300);
    check("R8 duty zero ctrl zero low", int'(pwm_o), 0);

    // R7: mid-period duty change must not reach pin before wrap
    wr_duty(8'h10);
    wr_ctrl(4'b0001);
    idle(40);
    wr_duty(8'h80);
    idle(60);
    check("R7 old duty kept mid period", int'(pwm_o), 0);
    idle(200);
    check("R7 new duty after wrap", int'(pwm_o), 1);

    for (int it = 0; it < 60; it++) begin
      int unsigned r;
      r = $urandom % 8;
      if (r < 3) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (r == 0) d = ($urandom % 2) ? 8'h00 : 8'hFF;
        wr_duty(d);
      end else if (r < 5) begin
        wr_ctrl(4'($urandom));
      end
      idle(1 + ($urandom % 700));
    end

    model_cmp = 1'b0;
    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule